// File: doc/BRIEF.md
# Host Bus Ownership Handoff Controller

This block sits inside a processor that is the current master of a shared external bus. It watches a request line from a host and request lines from peer processors. When the host asks for the bus, the block first turns off the processor's address, data, select and strobe drivers. It then leaves the grant line undriven for one clock, and after that drives the grant low. The grant stays low until the host drops its request. At that point the grant goes high and the bus drivers come back on in the same cycle.

The host always wins over peer processors. While the host owns the bus, or while a host request is pending, the block holds back its request to hand the bus to a peer. For asynchronous host accesses the block also drives a ready line. Ready goes low to add wait states while both the chip select and the host request are asserted.

The grant pin is split into an output enable and a value, so the undriven cycle can be seen directly. All request inputs and the chip select pass through a synchronizer before the block uses them.

Top module: `host_bus_handoff`

## Requirements
- R1: During and after synchronous reset (active-low `rst_n`) the block owns the bus: `bus_oe`=1, `hgnt_oe`=1, `hgnt_val`=1 (grant not asserted), `peer_yield`=0 and `host_rdy`=1.
- R2: Every input (`host_req`, `host_cs`, `peer_req`) is synchronized through two flip-flops. An input change that is set up before rising edge k first affects the outputs just after edge k+1.
- R3: In the cycle after the synchronized host request is first seen high while the block owns the bus, `bus_oe` goes to 0 and `hgnt_oe` goes to 0.
- R4: The grant line stays undriven (`hgnt_oe`=0) for exactly one cycle. After that cycle it is driven with `hgnt_val`=0 (grant asserted), provided the synchronized request is still high.
- R5: While the synchronized host request stays high, the grant stays driven low and `bus_oe` stays 0.
- R6: In the cycle after the synchronized host request falls while the grant is asserted, `hgnt_val` returns to 1 and `bus_oe` returns to 1 together.
- R7: If the synchronized request falls during the undriven cycle, the block returns to bus ownership (`bus_oe`=1, `hgnt_oe`=1, `hgnt_val`=1) without ever asserting the grant.
- R8: `bus_oe`=1 never occurs together with a driven-low grant (`hgnt_oe`=1 and `hgnt_val`=0).
- R9: `peer_yield` is 1 exactly when the block owns the bus, the synchronized host request is 0, and at least one synchronized peer request is 1. The host request therefore takes priority over all peers.
- R10: `host_rdy` is 0 exactly when the synchronized chip select and the synchronized host request are both 1; otherwise it is 1.
- R11: Peer requests have no effect on any output while the host holds the bus (`bus_oe`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Host bus request, active high, asynchronous |
| host_cs | input | 1 | Host chip select for asynchronous accesses, active high |
| peer_req | input | NUM_PEERS | Bus requests from peer processors, active high |
| bus_oe | output | 1 | Enable for the address, data, select and strobe drivers |
| hgnt_oe | output | 1 | Output enable of the host grant pin |
| hgnt_val | output | 1 | Value of the host grant pin; 0 means granted |
| host_rdy | output | 1 | Host ready; 0 inserts a wait state |
| peer_yield | output | 1 | Request to hand the bus over to a peer |

## Verification
The assertions assume that reset is held for at least two clocks, so that the synchronizer stages hold known values. They also assume that all inputs are changed only away from the rising edge. The bench drives every input on the falling edge. It holds reset low for several cycles before it releases it. Host requests are kept for random lengths, and these include one-cycle pulses that land in the undriven gap.

// File: rtl/host_bus_handoff_pkg.sv
// Package: shared types for the host bus handoff controller.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package host_bus_handoff_pkg;

    // Ownership phase of the external bus as seen by this processor.
    typedef enum logic [1:0] {
        PH_OWN  = 2'd0,   // this processor masters the bus
        PH_GAP  = 2'd1,   // drivers off, grant pin undriven
        PH_HOST = 2'd2    // host owns the bus, grant driven low
    } own_phase_t;

endpackage

// File: rtl/hbh_sync.sv
// Module: multi-stage flip-flop synchronizer for a bundle of asynchronous bits.
// Assumes: each bit is independent; no bundle coherence is required.
module hbh_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw inputs through STAGES flops, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hbh_phase_fsm.sv
// Module: sequences bus release, the one-cycle undriven grant gap, the host
// grant hold, and the return to ownership.
// Assumes: req_s is already synchronous to clk.
module hbh_phase_fsm
    import host_bus_handoff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    output logic bus_oe,
    output logic gnt_oe,
    output logic gnt_val,
    output logic owning
);
    own_phase_t phase, phase_nx;

    // Next-phase selection from the synchronized host request.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_OWN:  if (req_s) phase_nx = PH_GAP;
            PH_GAP:  phase_nx = req_s ? PH_HOST : PH_OWN;
            PH_HOST: if (!req_s) phase_nx = PH_OWN;
            default: phase_nx = PH_OWN;
        endcase
    end

    // Phase register, reset to ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_OWN;
        else        phase <= phase_nx;
    end

    // Pin controls decoded from the phase register.
    always_comb begin
        bus_oe  = (phase == PH_OWN);
        gnt_oe  = (phase != PH_GAP);
        gnt_val = (phase != PH_HOST);
        owning  = (phase == PH_OWN);
    end

    // R4: the undriven gap never lasts beyond one cycle.
    assert_gap_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_oe |=> gnt_oe);
    // R3: drivers drop while the grant pin is in its gap.
    assert_release_before_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> !gnt_oe);
    // R8: never drive the bus while the grant is low.
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && gnt_oe && !gnt_val));
    // R5: a held request keeps the grant asserted.
    assert_grant_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_oe && !gnt_val && req_s) |=> (gnt_oe && !gnt_val && !bus_oe));
endmodule

// File: rtl/hbh_host_port.sv
// Module: host ready generation and peer handoff gating with host priority.
// Assumes: all inputs are synchronized; owning comes from the phase FSM.
module hbh_host_port #(
    parameter int NUM_PEERS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_s,
    input  logic                 cs_s,
    input  logic [NUM_PEERS-1:0] peer_s,
    input  logic                 owning,
    output logic                 rdy,
    output logic                 yield
);
    // Wait-state insertion for asynchronous host accesses.
    always_comb rdy = !(cs_s && req_s);

    // Peer handoff only when owning and no host request is pending.
    always_comb yield = owning && !req_s && (|peer_s);

    // R9: host request blocks any peer handoff.
    assert_host_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_s |-> !yield);
    // R11: no peer handoff while the bus is not ours.
    assert_peer_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !owning |-> !yield);
endmodule

// File: rtl/host_bus_handoff.sv
// Module: top of the host bus ownership handoff controller.
// Assumes: inputs may be asynchronous; outputs drive pad enables directly.
module host_bus_handoff #(
    parameter int NUM_PEERS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_cs,
    input  logic [NUM_PEERS-1:0] peer_req,
    output logic                 bus_oe,
    output logic                 hgnt_oe,
    output logic                 hgnt_val,
    output logic                 host_rdy,
    output logic                 peer_yield
);
    localparam int SW = NUM_PEERS + 2;

    logic [SW-1:0]        raw_in, sync_out;
    logic                 req_s, cs_s, owning;
    logic [NUM_PEERS-1:0] peer_s;

    assign raw_in = {peer_req, host_cs, host_req};
    assign req_s  = sync_out[0];
    assign cs_s   = sync_out[1];
    assign peer_s = sync_out[SW-1:2];

    hbh_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_out)
    );

    hbh_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_s(req_s),
        .bus_oe(bus_oe), .gnt_oe(hgnt_oe), .gnt_val(hgnt_val), .owning(owning)
    );

    hbh_host_port #(.NUM_PEERS(NUM_PEERS)) u_port (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .cs_s(cs_s), .peer_s(peer_s),
        .owning(owning), .rdy(host_rdy), .yield(peer_yield)
    );

    // R6: release of the grant restores the drivers in the same cycle.
    assert_return_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hgnt_val) |-> bus_oe);
endmodule

// File: tb/host_bus_handoff_test.sv
module host_bus_handoff_test;
    localparam int NP = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 1'b0, host_cs = 1'b0;
    logic [NP-1:0] peer_req = '0;
    logic bus_oe, hgnt_oe, hgnt_val, host_rdy, peer_yield;

    int n_chk = 0, n_bad = 0, cyc = 0;

    host_bus_handoff #(.NUM_PEERS(NP), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_cs(host_cs),
        .peer_req(peer_req), .bus_oe(bus_oe), .hgnt_oe(hgnt_oe),
        .hgnt_val(hgnt_val), .host_rdy(host_rdy), .peer_yield(peer_yield)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Reference model built from R2 (two-flop sync) and R3..R7 (phases).
    logic r1_req, r2_req, r1_cs, r2_cs;
    logic [NP-1:0] r1_p, r2_p;
    int m_ph;  // 0 own, 1 gap, 2 host

    function automatic int next_ph(int ph, logic rq);
        if (ph == 0) return rq ? 1 : 0;
        if (ph == 1) return rq ? 2 : 0;
        return rq ? 2 : 0;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            r1_req <= 0; r2_req <= 0; r1_cs <= 0; r2_cs <= 0;
            r1_p <= '0; r2_p <= '0; m_ph <= 0;
        end else begin
            r1_req <= host_req; r2_req <= r1_req;
            r1_cs <= host_cs;   r2_cs <= r1_cs;
            r1_p <= peer_req;   r2_p <= r1_p;
            m_ph <= next_ph(m_ph, r2_req);
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    // Compare all outputs against the model, just after the falling edge.
    task automatic compare_all();
        chk(bus_oe,     m_ph == 0,                        "R3/R6 bus_oe");
        chk(hgnt_oe,    m_ph != 1,                        "R4 hgnt_oe");
        chk(hgnt_val,   m_ph != 2,                        "R5/R7 hgnt_val");
        chk(host_rdy,   !(r2_cs && r2_req),               "R10 host_rdy");
        chk(peer_yield, (m_ph == 0) && !r2_req && (|r2_p), "R9/R11 peer_yield");
        chk(!(bus_oe && hgnt_oe && !hgnt_val), 1'b1,      "R8 overlap");
    endtask

    task automatic step();
        @(negedge clk);
        #1 compare_all();
    endtask

    // Watchdog: expiry counts as a failed check and ends with the summary.
    initial begin
        #(150000 * 20);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state.
        repeat (4) @(negedge clk);
        #1;
        chk(bus_oe, 1'b1, "R1 bus_oe"); chk(hgnt_oe, 1'b1, "R1 hgnt_oe");
        chk(hgnt_val, 1'b1, "R1 hgnt_val"); chk(peer_yield, 1'b0, "R1 peer_yield");
        chk(host_rdy, 1'b1, "R1 host_rdy");
        rst_n = 1'b1;
        step();

        // R2/R3/R4: directed handoff; output must not move after one edge.
        host_req = 1'b1;
        step(); chk(bus_oe, 1'b1, "R2 no early release");
        step(); step(); chk(hgnt_oe, 1'b0, "R4 gap cycle");
        step(); chk(hgnt_val, 1'b0, "R4 grant driven low");
        // R11: peers while host holds.
        peer_req = '1;
        repeat (4) step();
        chk(peer_yield, 1'b0, "R11 peer ignored");
        host_req = 1'b0;
        repeat (3) step();
        chk(bus_oe, 1'b1, "R6 drivers back");
        chk(peer_yield, 1'b1, "R9 peer after release");
        peer_req = '0;
        repeat (3) step();

        // R7: one-cycle pulse lands in the gap.
        host_req = 1'b1; step(); host_req = 1'b0;
        repeat (2) step(); chk(hgnt_oe, 1'b0, "R7 gap seen");
        step(); chk(hgnt_val, 1'b1, "R7 no grant");
        repeat (3) step();

        // R9: simultaneous host and peer requests.
        host_req = 1'b1; peer_req = 6'b000100;
        repeat (2) step(); chk(peer_yield, 1'b0, "R9 host wins");
        host_cs = 1'b1; repeat (2) step();
        chk(host_rdy, 1'b0, "R10 wait state");
        host_req = 1'b0; host_cs = 1'b0; peer_req = '0;
        repeat (4) step();

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) host_req = ~host_req;
            if ($urandom_range(0, 3) == 0) host_cs = $urandom_range(0, 1);
            if ($urandom_range(0, 5) == 0) peer_req = NP'($urandom);
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule